// File: doc/BRIEF.md
# Interrupt Priority and Mask Arbiter

This block chooses which pending interrupt the CPU takes next. It receives a vector of pending maskable requests, one priority bit for each source, a non-maskable request, a two-bit control-mode field and the two CPU mask flags I and UI. From these it forms a three-level mask and selects one winner with combinational logic. When the CPU signals that it can take an interrupt, the block registers the choice. It then shows it for one clock as an accept strobe with the source index, together with the I/UI values the CPU should load once it has taken the interrupt.

The non-maskable request always wins and is never masked. The other sources are ordered first by their priority bit and then by lowest index. The control mode sets whether the priority bit also takes part in masking. Edge detection, vector generation and context stacking happen outside this block.

Top module: `irq_mask_arbiter`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, accept_o, accept_nmi_o, accept_idx_o, mask_i_o and mask_ui_o are all 0.
- R2: accept_o is high for exactly the one cycle that follows a rising clock edge at which cpu_ready_i was 1 and a winner existed. It stays low after any edge at which cpu_ready_i was 0.
- R3: A high nmi_i is accepted in every mode and for every flag value, ahead of all maskable sources. The strobe then shows accept_nmi_o=1 and accept_idx_o=0.
- R4: mode_i=2'b10 selects priority mode. The encodings 2'b00, 2'b01 and 2'b11 all select simple mode.
- R5: In simple mode, i_flag_i=1 masks every maskable source and i_flag_i=0 lets every pending source through, whatever ui_flag_i and prio_i hold.
- R6: In priority mode with i_flag_i=0, every pending source is eligible.
- R7: In priority mode with i_flag_i=1 and ui_flag_i=0, only sources whose prio_i bit is 1 are eligible.
- R8: In priority mode with i_flag_i=1 and ui_flag_i=1, every maskable source is masked.
- R9: Among eligible sources, one with prio_i=1 beats one with prio_i=0. Within the same priority, the lowest index wins. This ordering applies in both modes.
- R10: With a strobe, mask_i_o is 1. In simple mode, mask_ui_o repeats the sampled ui_flag_i. In priority mode, mask_ui_o is 1 after an NMI or a high-priority source and 0 after a low-priority source.
- R11: If nmi_i is low and no source is eligible, accept_o stays low even while cpu_ready_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | N_SRC | Pending maskable requests, one bit per source |
| prio_i | input | N_SRC | Priority bit per source, 1 = high |
| nmi_i | input | 1 | Non-maskable request |
| mode_i | input | 2 | Control mode select (2'b10 priority, others simple) |
| i_flag_i | input | 1 | CPU I mask flag |
| ui_flag_i | input | 1 | CPU UI mask flag |
| cpu_ready_i | input | 1 | CPU can accept an interrupt this cycle |
| accept_o | output | 1 | One-cycle accept strobe |
| accept_nmi_o | output | 1 | The accepted request is the NMI |
| accept_idx_o | output | IDX_W | Index of the accepted maskable source |
| mask_i_o | output | 1 | I value to load after acceptance |
| mask_ui_o | output | 1 | UI value to load after acceptance |

## Verification
The assertions assume that requests, priority bits, mode and flags are stable around each rising edge. They also assume that cpu_ready_i is a clean synchronous level, because each clocked property compares a registered strobe with the input values of the previous cycle. The bench meets this by changing every input only on the falling clock edge. It raises cpu_ready_i for a single cycle per scenario and samples the strobe at the next falling edge, which keeps each previous-cycle sample unambiguous.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  typedef enum logic {
    MODE_SIMPLE = 1'b0,
    MODE_PRIO   = 1'b1
  } ctl_mode_e;

  // only 2'b10 selects priority mode; reserved codes fall back to simple
  function automatic ctl_mode_e decode_mode(input logic [1:0] code);
    return (code == 2'b10) ? MODE_PRIO : MODE_SIMPLE;
  endfunction

endpackage

// File: rtl/irq_mask_filter.sv
module irq_mask_filter
  import irq_arb_pkg::*;
#(
  parameter int unsigned N_SRC = 16
) (
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] prio_i,
  input  ctl_mode_e        mode_i,
  input  logic             i_flag_i,
  input  logic             ui_flag_i,
  output logic [N_SRC-1:0] elig_o
);

  logic pass_low;
  logic pass_high;

  always_comb begin
    if (mode_i == MODE_PRIO) begin
      pass_low  = !i_flag_i;
      pass_high = !i_flag_i || !ui_flag_i;
    end else begin
      pass_low  = !i_flag_i;
      pass_high = !i_flag_i;
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign elig_o[g] = req_i[g] && (prio_i[g] ? pass_high : pass_low);
  end

  // R8
  always_comb begin
    if (mode_i == MODE_PRIO && i_flag_i && ui_flag_i) begin
      full_mask_chk: assert (elig_o == '0);
    end
  end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N_SRC = 16,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] elig_i,
  input  logic [N_SRC-1:0] prio_i,
  output logic             valid_o,
  output logic             high_o,
  output logic [IDX_W-1:0] idx_o
);

  logic [N_SRC-1:0] high_vec;
  logic [N_SRC-1:0] low_vec;
  logic [N_SRC-1:0] pick_vec;

  assign high_vec = elig_i & prio_i;
  assign low_vec  = elig_i & ~prio_i;
  assign high_o   = |high_vec;
  assign valid_o  = |elig_i;
  assign pick_vec = high_o ? high_vec : low_vec;

  always_comb begin
    idx_o = '0;
    for (int k = N_SRC - 1; k >= 0; k--) begin
      if (pick_vec[k]) idx_o = IDX_W'(k);
    end
  end

  // R9
  always_comb begin
    if (valid_o) begin
      pick_elig_chk: assert (elig_i[idx_o] && (prio_i[idx_o] == high_o));
    end
  end

endmodule

// File: rtl/irq_mask_arbiter.sv
module irq_mask_arbiter
  import irq_arb_pkg::*;
#(
  parameter int unsigned N_SRC = 16,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] prio_i,
  input  logic             nmi_i,
  input  logic [1:0]       mode_i,
  input  logic             i_flag_i,
  input  logic             ui_flag_i,
  input  logic             cpu_ready_i,
  output logic             accept_o,
  output logic             accept_nmi_o,
  output logic [IDX_W-1:0] accept_idx_o,
  output logic             mask_i_o,
  output logic             mask_ui_o
);

  ctl_mode_e        mode;
  logic [N_SRC-1:0] elig;
  logic             win_valid;
  logic             win_high;
  logic [IDX_W-1:0] win_idx;
  logic             take;
  logic             next_ui;

  assign mode = decode_mode(mode_i);

  irq_mask_filter #(.N_SRC(N_SRC)) filter_i (
    .req_i    (req_i),
    .prio_i   (prio_i),
    .mode_i   (mode),
    .i_flag_i (i_flag_i),
    .ui_flag_i(ui_flag_i),
    .elig_o   (elig)
  );

  irq_prio_pick #(.N_SRC(N_SRC)) pick_i (
    .elig_i (elig),
    .prio_i (prio_i),
    .valid_o(win_valid),
    .high_o (win_high),
    .idx_o  (win_idx)
  );

  assign take = cpu_ready_i && (nmi_i || win_valid);

  always_comb begin
    if (mode == MODE_PRIO) next_ui = nmi_i || win_high;
    else                   next_ui = ui_flag_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o     <= 1'b0;
      accept_nmi_o <= 1'b0;
      accept_idx_o <= '0;
      mask_i_o     <= 1'b0;
      mask_ui_o    <= 1'b0;
    end else begin
      accept_o     <= take;
      accept_nmi_o <= take && nmi_i;
      accept_idx_o <= (take && !nmi_i) ? win_idx : '0;
      mask_i_o     <= take;
      mask_ui_o    <= take && next_ui;
    end
  end

  // R2
  property strobe_needs_ready_p;
    @(posedge clk_i) disable iff (!rst_ni) accept_o |-> $past(cpu_ready_i);
  endproperty
  strobe_ready_chk: assert property (strobe_needs_ready_p);

  // R3
  property nmi_first_p;
    @(posedge clk_i) disable iff (!rst_ni) (accept_o && $past(nmi_i)) |-> accept_nmi_o;
  endproperty
  nmi_first_chk: assert property (nmi_first_p);

  // R5
  property simple_mask_p;
    @(posedge clk_i) disable iff (!rst_ni)
      (accept_o && !accept_nmi_o) |-> !($past(mode_i) != 2'b10 && $past(i_flag_i));
  endproperty
  simple_mask_chk: assert property (simple_mask_p);

  // R8
  property prio_full_mask_p;
    @(posedge clk_i) disable iff (!rst_ni)
      (accept_o && $past(mode_i) == 2'b10 && $past(i_flag_i) && $past(ui_flag_i)) |-> accept_nmi_o;
  endproperty
  prio_full_mask_chk: assert property (prio_full_mask_p);

  // R10
  property mask_i_set_p;
    @(posedge clk_i) disable iff (!rst_ni) accept_o |-> mask_i_o;
  endproperty
  mask_i_set_chk: assert property (mask_i_set_p);

endmodule

// File: tb/irq_mask_arbiter_tb_top.sv
module irq_mask_arbiter_tb_top;

  localparam int N = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  req_i = '0;
  logic [N-1:0]  prio_i = '0;
  logic          nmi_i = 1'b0;
  logic [1:0]    mode_i = 2'b00;
  logic          i_flag_i = 1'b0;
  logic          ui_flag_i = 1'b0;
  logic          cpu_ready_i = 1'b0;
  logic          accept_o;
  logic          accept_nmi_o;
  logic [3:0]    accept_idx_o;
  logic          mask_i_o;
  logic          mask_ui_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  irq_mask_arbiter #(.N_SRC(N)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .prio_i(prio_i),
    .nmi_i(nmi_i), .mode_i(mode_i), .i_flag_i(i_flag_i), .ui_flag_i(ui_flag_i),
    .cpu_ready_i(cpu_ready_i), .accept_o(accept_o), .accept_nmi_o(accept_nmi_o),
    .accept_idx_o(accept_idx_o), .mask_i_o(mask_i_o), .mask_ui_o(mask_ui_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setup(input logic [1:0] m, input logic fi, input logic fu,
                       input logic [N-1:0] rq, input logic [N-1:0] pr, input logic nm);
    mode_i = m; i_flag_i = fi; ui_flag_i = fu; req_i = rq; prio_i = pr; nmi_i = nm;
  endtask

  // one-cycle ready pulse, then check the strobe and that it drops again
  task automatic pulse(input string tag, input logic ev, input logic en,
                       input logic [3:0] ei, input logic eu);
    cpu_ready_i = 1'b1;
    @(negedge clk_i);
    cpu_ready_i = 1'b0;
    check({tag, " accept"}, 32'(accept_o), 32'(ev));
    if (ev) begin
      check({tag, " nmi"}, 32'(accept_nmi_o), 32'(en));
      check({tag, " idx"}, 32'(accept_idx_o), 32'(ei));
      check({tag, " mask_i R10"}, 32'(mask_i_o), 32'd1);
      check({tag, " mask_ui R10"}, 32'(mask_ui_o), 32'(eu));
    end
    @(negedge clk_i);
    check({tag, " strobe drops R2"}, 32'(accept_o), 32'd0);
  endtask

  task automatic t_reset;
    check("R1 accept", 32'(accept_o), 0);
    check("R1 nmi", 32'(accept_nmi_o), 0);
    check("R1 idx", 32'(accept_idx_o), 0);
    check("R1 mask", 32'({mask_i_o, mask_ui_o}), 0);
  endtask

  task automatic t_no_ready;
    setup(2'b00, 0, 0, 16'h0008, 16'h0000, 1);
    @(negedge clk_i);
    @(negedge clk_i);
    check("R2 no ready", 32'(accept_o), 0);
    nmi_i = 0;
  endtask

  task automatic t_simple;
    setup(2'b00, 0, 0, 16'h0028, 16'h0000, 0);
    pulse("R5 simple open", 1, 0, 4'd3, 0);
    setup(2'b00, 1, 0, 16'h0028, 16'h0028, 0);
    pulse("R5 simple masked", 0, 0, 0, 0);
    setup(2'b00, 1, 1, 16'h0028, 16'h0000, 1);
    pulse("R3 nmi simple", 1, 1, 4'd0, 1);
    setup(2'b00, 0, 0, 16'h0204, 16'h0200, 0);
    pulse("R9 simple high first", 1, 0, 4'd9, 0);
  endtask

  task automatic t_reserved;
    setup(2'b01, 1, 0, 16'h0080, 16'h0080, 0);
    pulse("R4 code01 simple", 0, 0, 0, 0);
    setup(2'b11, 0, 1, 16'h0010, 16'h0000, 0);
    pulse("R4 code11 simple", 1, 0, 4'd4, 1);
  endtask

  task automatic t_prio;
    setup(2'b10, 0, 0, 16'h0010, 16'h0000, 0);
    pulse("R6 prio open low", 1, 0, 4'd4, 0);
    setup(2'b10, 1, 0, 16'h0082, 16'h0080, 0);
    pulse("R7 prio high only", 1, 0, 4'd7, 1);
    setup(2'b10, 1, 0, 16'h0002, 16'h0080, 0);
    pulse("R7 prio low masked", 0, 0, 0, 0);
    setup(2'b10, 1, 1, 16'h0080, 16'h0080, 0);
    pulse("R8 prio all masked", 0, 0, 0, 0);
    setup(2'b10, 1, 1, 16'h0080, 16'h0080, 1);
    pulse("R3 nmi prio", 1, 1, 4'd0, 1);
    setup(2'b10, 0, 0, 16'h1040, 16'h1040, 0);
    pulse("R9 tie lowest", 1, 0, 4'd6, 1);
  endtask

  task automatic t_empty;
    setup(2'b10, 0, 0, 16'h0000, 16'hFFFF, 0);
    pulse("R11 nothing pending", 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_no_ready();
    t_simple();
    t_reserved();
    t_prio();
    t_empty();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule